// File: doc/BRIEF.md
# Post-Load Start-Up Sequencer

Once a programmable device has finished taking in its configuration data, this block runs the short start-up sequence that brings the device into operation. A load-complete strobe starts an eight-phase counter, phases 0 to 7, clocked by the configuration clock. The counter controls four release events. The first is the device's own done indication, which is driven onto an open-drain pin. The other three are the release of the global tristate, the release of the global set/reset, and the assertion of the global write enable.

Each event has its own 3-bit phase code. A code from 1 to 6 picks the phase in which the event switches on. Code 7 on any of the three release events selects synchronise-to-done mode. In that mode the event waits until the external, wire-ANDed done line is seen high. This lets chained devices leave start-up together. Every event stays on until reset. A completion flag rises after the counter has reached its last phase and all four events have fired.

Top module: `startup_seq`

## Requirements
- R1: While idle, a high `load_done_i` at a rising edge starts the sequence. The cycle after that edge is phase 0, and each later edge advances the phase by one. The counter stops at phase 7.
- R2: An event whose code c is between 1 and 6 first reads high in phase c, which is c cycles after the start edge.
- R3: Code 0 is reserved and acts as code 1, so the event first reads high in phase 1.
- R4: The done event has no synchronised mode. Code 7 on `done_code_i` acts as code 6.
- R5: Code 7 on a release event (`tris_code_i`, `gsr_code_i`, `gwe_code_i`) selects synchronise-to-done mode. The external pin passes through a two-flop synchroniser. The event reads high one cycle after the first running cycle in which both the synchronised pin level and `done_o` are high. With `done_o` already high, this is the third rising edge after the pin is first sampled high.
- R6: `done_oe_o` is high (pulling the pin low) from reset until the done event fires, and low from then on. `done_o` is its complement.
- R7: Every event output stays high until reset once it has risen.
- R8: `startup_cplt_o` rises one cycle after the first cycle in which the phase is 7 and all four event outputs are high. If a synchronised event never fires, `startup_cplt_o` stays low.
- R9: `load_done_i` is ignored while a sequence runs and after it has completed. Event timing and held outputs do not change.
- R10: During reset, all event outputs and `startup_cplt_o` are low and `done_oe_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| load_done_i | input | 1 | Configuration data fully loaded; starts the sequence |
| done_pin_i | input | 1 | Level seen on the external wire-ANDed done line |
| done_code_i | input | PH_W | Phase code of the done event |
| tris_code_i | input | PH_W | Phase code of the global tristate release |
| gsr_code_i | input | PH_W | Phase code of the global set/reset release |
| gwe_code_i | input | PH_W | Phase code of the global write enable |
| done_o | output | 1 | Internal done asserted |
| done_oe_o | output | 1 | Pull-low enable for the open-drain done pin |
| tris_rel_o | output | 1 | Global tristate released |
| gsr_rel_o | output | 1 | Global set/reset released |
| gwe_en_o | output | 1 | Global write enable asserted |
| startup_cplt_o | output | 1 | Start-up sequence complete |

## Verification
Two functions can land on the same clock edge.

The first case is a repeated load-complete strobe that is sampled on the same edge where a programmed event fires. The bench pulses the strobe again in the middle of a run, and again after completion. It then checks that every output still follows the timeline computed from the first start edge, with no restart to phase 0.

The second case is a synchronised release becoming ready in the same phase in which the done event itself fires. The bench raises the external pin before the done event. This makes the synchronised level high early, so the release must wait for `done_o` and then appear exactly one cycle later. The completion flag is judged against the cycle that follows.

// File: rtl/startup_pkg.sv
package startup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_st_e;

endpackage

// File: rtl/startup_sync2.sv
module startup_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_reg_t;

    sync_reg_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.sh = {r_q.sh[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_o = r_q.sh[STAGES-1];

endmodule

// File: rtl/startup_evt.sv
module startup_evt #(
    parameter int PH_W    = 3,
    parameter bit SYNC_OK = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] code_i,
    input  logic            run_next_i,
    input  logic [PH_W-1:0] ph_next_i,
    input  logic            sync_go_i,
    output logic            out_o
);

    localparam logic [PH_W-1:0] CODE_SYNC = '1;
    localparam logic [PH_W-1:0] CODE_TOP  = {{(PH_W-1){1'b1}}, 1'b0};
    localparam logic [PH_W-1:0] CODE_MIN  = {{(PH_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic out;
    } evt_reg_t;

    evt_reg_t        r_d, r_q;
    logic            sync_mode;
    logic [PH_W-1:0] eff_ph;
    logic            fire;

    always_comb begin
        sync_mode = SYNC_OK && (code_i == CODE_SYNC);
        if (code_i == '0)            eff_ph = CODE_MIN;
        else if (code_i == CODE_SYNC) eff_ph = CODE_TOP;
        else                          eff_ph = code_i;
        fire      = sync_mode ? sync_go_i : (run_next_i && (ph_next_i == eff_ph));
        r_d       = r_q;
        r_d.out   = r_q.out | fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_o = r_q.out;

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        out_o |=> out_o);                                                   // R7
    AST_EVT_SYNC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && $rose(out_o)) |-> $past(sync_go_i));                  // R5
    AST_EVT_CYCLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && $rose(out_o)) |-> $past(run_next_i));                // R2

endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_pkg::*;
#(
    parameter int PH_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_done_i,
    input  logic            done_pin_i,
    input  logic [PH_W-1:0] done_code_i,
    input  logic [PH_W-1:0] tris_code_i,
    input  logic [PH_W-1:0] gsr_code_i,
    input  logic [PH_W-1:0] gwe_code_i,
    output logic            done_o,
    output logic            done_oe_o,
    output logic            tris_rel_o,
    output logic            gsr_rel_o,
    output logic            gwe_en_o,
    output logic            startup_cplt_o
);

    localparam logic [PH_W-1:0] PH_LAST = '1;
    localparam int              N_REL   = 3;

    typedef struct packed {
        seq_st_e         st;
        logic [PH_W-1:0] ph;
        logic            cplt;
    } seq_reg_t;

    seq_reg_t        r_d, r_q;
    logic            ext_q;
    logic            done_q;
    logic [N_REL-1:0] rel_q;
    logic [PH_W-1:0] rel_code [N_REL];
    logic            all_q;
    logic            run_next;
    logic            sync_go;

    assign rel_code[0] = tris_code_i;
    assign rel_code[1] = gsr_code_i;
    assign rel_code[2] = gwe_code_i;
    assign all_q       = done_q & (&rel_q);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (load_done_i) begin
                    r_d.st = ST_RUN;
                    r_d.ph = '0;
                end
            end
            ST_RUN: begin
                if (r_q.ph != PH_LAST) begin
                    r_d.ph = r_q.ph + 1'b1;
                end else if (all_q) begin
                    r_d.st   = ST_FIN;
                    r_d.cplt = 1'b1;
                end
            end
            default: begin
                r_d = r_q;
            end
        endcase
        run_next = (r_d.st == ST_RUN);
        sync_go  = (r_q.st == ST_RUN) && done_q && ext_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.ph   <= '0;
            r_q.cplt <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    startup_sync2 #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (done_pin_i),
        .sync_o  (ext_q)
    );

    startup_evt #(.PH_W(PH_W), .SYNC_OK(1'b0)) u_evt_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_i     (done_code_i),
        .run_next_i (run_next),
        .ph_next_i  (r_d.ph),
        .sync_go_i  (1'b0),
        .out_o      (done_q)
    );

    for (genvar gi = 0; gi < N_REL; gi++) begin : g_rel
        startup_evt #(.PH_W(PH_W), .SYNC_OK(1'b1)) u_evt (
            .clk        (clk),
            .rst_n      (rst_n),
            .code_i     (rel_code[gi]),
            .run_next_i (run_next),
            .ph_next_i  (r_d.ph),
            .sync_go_i  (sync_go),
            .out_o      (rel_q[gi])
        );
    end

    assign done_o         = done_q;
    assign done_oe_o      = ~done_q;
    assign tris_rel_o     = rel_q[0];
    assign gsr_rel_o      = rel_q[1];
    assign gwe_en_o       = rel_q[2];
    assign startup_cplt_o = r_q.cplt;

    AST_PH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && r_q.ph != PH_LAST) |=> (r_q.ph == $past(r_q.ph) + 1'b1)); // R1
    AST_IGNORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && load_done_i) |=> (r_q.st != ST_IDLE && r_q.ph != '0));  // R9
    AST_CPLT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(startup_cplt_o) |-> $past(r_q.ph == PH_LAST && all_q));                 // R8
    AST_CPLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        startup_cplt_o |=> startup_cplt_o);                                            // R7

endmodule

// File: tb/startup_seq_bench.sv
module startup_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_done_i = 1'b0;
    logic       done_pin_i = 1'b0;
    logic [2:0] done_code_i = 3'd1;
    logic [2:0] tris_code_i = 3'd1;
    logic [2:0] gsr_code_i = 3'd1;
    logic [2:0] gwe_code_i = 3'd1;
    logic       done_o, done_oe_o, tris_rel_o, gsr_rel_o, gwe_en_o, startup_cplt_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    startup_seq u_startup_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_done_i    (load_done_i),
        .done_pin_i     (done_pin_i),
        .done_code_i    (done_code_i),
        .tris_code_i    (tris_code_i),
        .gsr_code_i     (gsr_code_i),
        .gwe_code_i     (gwe_code_i),
        .done_o         (done_o),
        .done_oe_o      (done_oe_o),
        .tris_rel_o     (tris_rel_o),
        .gsr_rel_o      (gsr_rel_o),
        .gwe_en_o       (gwe_en_o),
        .startup_cplt_o (startup_cplt_o)
    );

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // expected first phase (cycles after start edge) at which an event reads high
    function automatic int rise_of(logic [2:0] code, bit is_done, int done_rise, int pin_k);
        if (code == 3'd0) return 1;                       // R3
        if (code == 3'd7) begin
            if (is_done) return 6;                        // R4
            if (pin_k < 0) return 100000;                 // R5 never
            return max2(pin_k + 2, done_rise) + 1;        // R5
        end
        return int'(code);                                // R2
    endfunction

    function automatic string req_of(logic [2:0] code, bit is_done);
        if (code == 3'd0) return "R3";
        if (code == 3'd7) return is_done ? "R4" : "R5";
        return "R2";
    endfunction

    task automatic do_reset(logic [2:0] d, logic [2:0] t, logic [2:0] g, logic [2:0] w);
        @(negedge clk);
        rst_n       = 1'b0;
        load_done_i = 1'b0;
        done_pin_i  = 1'b0;
        done_code_i = d;
        tris_code_i = t;
        gsr_code_i  = g;
        gwe_code_i  = w;
        repeat (3) @(negedge clk);
        check("R10 reset done_o", done_o, 1'b0);
        check("R10 reset done_oe_o R6", done_oe_o, 1'b1);
        check("R10 reset tris", tris_rel_o, 1'b0);
        check("R10 reset gsr", gsr_rel_o, 1'b0);
        check("R10 reset gwe", gwe_en_o, 1'b0);
        check("R10 reset cplt", startup_cplt_o, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // one scenario: reset, start, walk k cycles comparing with computed timeline
    task automatic run_scn(string name, logic [2:0] d, logic [2:0] t, logic [2:0] g,
                           logic [2:0] w, int pin_k, int reload_k, int n_cyc);
        int rd, rt, rg, rw, last, rc;
        do_reset(d, t, g, w);
        rd   = rise_of(d, 1'b1, 0, pin_k);
        rt   = rise_of(t, 1'b0, rd, pin_k);
        rg   = rise_of(g, 1'b0, rd, pin_k);
        rw   = rise_of(w, 1'b0, rd, pin_k);
        last = max2(max2(rd, rt), max2(rg, rw));
        rc   = max2(7, last) + 1;
        load_done_i = 1'b1;                               // R1 start strobe
        @(negedge clk);
        load_done_i = 1'b0;
        for (int k = 0; k <= n_cyc; k++) begin
            check($sformatf("%s k=%0d done %s", name, k, req_of(d, 1'b1)), done_o, (k >= rd));
            check($sformatf("%s k=%0d done_oe R6", name, k), done_oe_o, !(k >= rd));
            check($sformatf("%s k=%0d tris %s", name, k, req_of(t, 1'b0)), tris_rel_o, (k >= rt));
            check($sformatf("%s k=%0d gsr %s", name, k, req_of(g, 1'b0)), gsr_rel_o, (k >= rg));
            check($sformatf("%s k=%0d gwe %s", name, k, req_of(w, 1'b0)), gwe_en_o, (k >= rw));
            check($sformatf("%s k=%0d cplt R8", name, k), startup_cplt_o, (k >= rc));
            load_done_i = (k == reload_k);                // R9 repeated strobe
            if (k == pin_k) done_pin_i = 1'b1;
            @(negedge clk);
        end
        load_done_i = 1'b0;
    endtask

    task automatic scn_reset_state();
        do_reset(3'd1, 3'd1, 3'd1, 3'd1);
        repeat (4) @(negedge clk);
        check("R10 idle without strobe keeps done_oe_o R6", done_oe_o, 1'b1);
        check("R1 idle without strobe no release", tris_rel_o | gsr_rel_o | gwe_en_o, 1'b0);
    endtask

    task automatic scn_distinct();   // R2 distinct phases, R7 and R9 strobe after completion
        run_scn("R2_R7_R9 distinct", 3'd5, 3'd1, 3'd3, 3'd6, -1, 10, 14);
    endtask

    task automatic scn_same_phase(); // R1 all events on one phase
        run_scn("R1 same phase", 3'd4, 3'd4, 3'd4, 3'd4, -1, -1, 10);
    endtask

    task automatic scn_code_zero();  // R3
        run_scn("R3 code zero", 3'd0, 3'd0, 3'd2, 3'd0, -1, -1, 10);
    endtask

    task automatic scn_done_code7(); // R4
        run_scn("R4 done code7", 3'd7, 3'd6, 3'd5, 3'd2, -1, -1, 10);
    endtask

    task automatic scn_sync_late();  // R5 pin rises long after done
        run_scn("R5 sync late pin", 3'd3, 3'd7, 3'd7, 3'd2, 10, -1, 17);
    endtask

    task automatic scn_sync_early(); // R5 pin high before done fires
        run_scn("R5 sync early pin", 3'd6, 3'd7, 3'd1, 3'd7, 0, -1, 11);
    endtask

    task automatic scn_reload_mid(); // R9 strobe mid-run on the edge an event fires
        run_scn("R9 reload mid", 3'd4, 3'd2, 3'd5, 3'd4, -1, 3, 10);
    endtask

    task automatic scn_sync_never(); // R8 no completion without pin
        run_scn("R8 sync never", 3'd2, 3'd3, 3'd7, 3'd1, -1, -1, 14);
    endtask

    initial begin
        scn_reset_state();
        scn_distinct();
        scn_same_phase();
        scn_code_zero();
        scn_done_code7();
        scn_sync_late();
        scn_sync_early();
        scn_reload_mid();
        scn_sync_never();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule